// File: doc/BRIEF.md
# Phase-Cut Dimmer Mode Classifier

This block decides which kind of phase-cut control sits on the mains feed of a lamp driver: no dimmer, a leading-edge dimmer, or a trailing-edge dimmer. Once per rectified half line-cycle, a front end hands it three flags digitised from the line: whether the half-cycle was phase cut at all, whether the cut ended in a fast rising edge, and whether the falling side had a steep slope. Each flag set is qualified by a one-cycle half-cycle strobe. The block reduces each half-cycle to a single class and turns those classes into a stable operating mode for the boost and output control stages.

After reset, and whenever supply-good is low, the block sits in a learn phase. It collects a fixed number of half-cycles (four by default, about two line cycles) and then commits to the class seen most often. It then enters a validate phase. There, a saturating up/down counter tracks how often new half-cycles disagree with the committed mode. At the end of each validate period this count is compared with a re-learn level. A large count sends the block back to learning, so an isolated noisy half-cycle can never change the mode.

Top module: `dimmer_mode_det`

## Requirements
- R1: While rst_n is low, and after reset while pwr_good has not yet risen, mode is 2'b00 and mode_valid is 0.
- R2: Each strobed half-cycle is classed as follows. cut_seen=0 gives none (code 2'b00). cut_seen=1 with fast_rise=1 gives leading (2'b01). cut_seen=1, fast_rise=0 and steep_fall=1 gives trailing (2'b10). cut_seen=1 with both other flags 0 gives leading. Code 2'b11 never appears on mode.
- R3: Learning ends on exactly the LEARN_HC-th strobe counted from entry into learning. mode_valid rises in that same clock cycle, and stays 0 after fewer strobes.
- R4: The committed mode is the class with the largest count among the learn strobes. On a tie, the lower code wins.
- R5: Flag inputs without hc_stb have no effect on mode, on mode_valid or on later decisions.
- R6: In validate, a filter counter of FILT_W bits moves up by one on a disagreeing strobe and down by one on an agreeing strobe. It saturates at 0 and at 2^FILT_W-1, and it starts at 0 on entry to validate.
- R7: Every VAL_PERIOD-th validate strobe is a check point. If the filter value after that strobe is at least RELEARN_LVL, the block returns to learning in that cycle: mode_valid goes to 0 and mode to 2'b00.
- R8: When a check point finds the filter below RELEARN_LVL, the mode stays. The filter value carries over into the next period.
- R9: A single disagreeing half-cycle in validate never changes mode or mode_valid.
- R10: pwr_good low forces the learn phase on the next edge, with mode 2'b00 and mode_valid 0. Strobes are ignored while pwr_good is low, and learning restarts from zero when it returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply-good; low holds the block in learning |
| hc_stb | input | 1 | One-cycle strobe, once per half line-cycle |
| cut_seen | input | 1 | Half-cycle was phase cut |
| fast_rise | input | 1 | Cut ended with a fast rising edge |
| steep_fall | input | 1 | Falling side of the half-cycle was steep |
| mode | output | 2 | 00 none, 01 leading-edge, 10 trailing-edge |
| mode_valid | output | 1 | High in the validate phase |

## Verification
A strobe or a pwr_good change is sampled on one rising edge, and mode and mode_valid are registered on that same edge. Every result is therefore due one edge after the stimulus. The bench drives each input on a falling edge, lets exactly one rising edge pass, and compares on the next falling edge against its own arithmetic model of tallies, filter and period. The filter saturation tests use sequences whose outcome at the check point differs between a saturating counter and a plain one. This makes the hidden counter observable at mode_valid.

// File: rtl/dimmer_det_pkg.sv
package dimmer_det_pkg;

  localparam logic [1:0] MODE_NONE  = 2'b00;
  localparam logic [1:0] MODE_LEAD  = 2'b01;
  localparam logic [1:0] MODE_TRAIL = 2'b10;

  typedef enum logic {ST_LEARN = 1'b0, ST_VALID = 1'b1} det_state_t;

  // One half-cycle's flags reduced to a class code.
  function automatic logic [1:0] classify_hc(input logic cut, input logic rise,
                                             input logic fall);
    if (!cut)      return MODE_NONE;
    else if (rise) return MODE_LEAD;
    else if (fall) return MODE_TRAIL;
    else           return MODE_LEAD;
  endfunction

  // Largest tally wins; ties resolve toward the lower code.
  function automatic logic [1:0] vote3(input int n_none, input int n_lead,
                                       input int n_trail);
    if (n_none >= n_lead && n_none >= n_trail) return MODE_NONE;
    else if (n_lead >= n_trail)                return MODE_LEAD;
    else                                       return MODE_TRAIL;
  endfunction

  // Saturating step of the disagreement filter.
  function automatic int sat_step(input int v, input logic up, input int top);
    if (up) return (v >= top) ? top : v + 1;
    else    return (v <= 0) ? 0 : v - 1;
  endfunction

endpackage

// File: rtl/dd_classify.sv
module dd_classify
  import dimmer_det_pkg::*;
(
  input  logic       cut_seen,
  input  logic       fast_rise,
  input  logic       steep_fall,
  output logic [1:0] hc_class
);
  always_comb hc_class = classify_hc(cut_seen, fast_rise, steep_fall);
endmodule

// File: rtl/dd_learn.sv
module dd_learn
  import dimmer_det_pkg::*;
#(
  parameter int LEARN_HC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       stb,
  input  logic [1:0] hc_class,
  output logic       done,
  output logic [1:0] decision
);
  localparam int CNT_W = $clog2(LEARN_HC + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tally      [3];
  logic [CNT_W-1:0] tally_next [3];

  assign done     = en && stb && (cnt == CNT_W'(LEARN_HC - 1));
  assign decision = vote3(int'(tally_next[0]), int'(tally_next[1]), int'(tally_next[2]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!en || done)    cnt <= '0;
    else if (stb)            cnt <= cnt + 1'b1;
  end

  for (genvar k = 0; k < 3; k++) begin : g_tally
    assign tally_next[k] = tally[k] + CNT_W'(stb && (hc_class == 2'(k)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           tally[k] <= '0;
      else if (!en || done) tally[k] <= '0;
      else                  tally[k] <= tally_next[k];
    end
  end

  // R3: the per-class tallies always add up to the strobes counted so far
  p_tally_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ({2'b00, tally[0]} + {2'b00, tally[1]} + {2'b00, tally[2]}) == {2'b00, cnt});
  // R3: learning never counts past its length
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < LEARN_HC);
endmodule

// File: rtl/dd_filter.sv
module dd_filter
  import dimmer_det_pkg::*;
#(
  parameter int FILT_W      = 4,
  parameter int VAL_PERIOD  = 64,
  parameter int RELEARN_LVL = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic stb,
  input  logic disagree,
  output logic relearn
);
  localparam int FMAX  = (1 << FILT_W) - 1;
  localparam int PER_W = $clog2(VAL_PERIOD);

  logic [FILT_W-1:0] filt;
  logic [FILT_W-1:0] filt_next;
  logic [PER_W-1:0]  per;
  logic              period_end;

  assign filt_next  = FILT_W'(sat_step(int'(filt), disagree, FMAX));
  assign period_end = (per == PER_W'(VAL_PERIOD - 1));
  assign relearn    = en && stb && period_end && (int'(filt_next) >= RELEARN_LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt <= '0;
      per  <= '0;
    end else if (!en) begin
      filt <= '0;
      per  <= '0;
    end else if (stb) begin
      filt <= filt_next;
      per  <= period_end ? '0 : per + 1'b1;
    end
  end

  // R6: without a strobe the filter does not move
  p_filt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !stb) |=> $stable(filt));
  // R7: reaching the level needs a filter already one step below it
  p_relearn_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    relearn |-> (int'(filt) >= RELEARN_LVL - 1));
  // R6: the filter is clear whenever validation is off
  p_filt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (filt == '0));
endmodule

// File: rtl/dimmer_mode_det.sv
module dimmer_mode_det
  import dimmer_det_pkg::*;
#(
  parameter int LEARN_HC    = 4,
  parameter int VAL_PERIOD  = 64,
  parameter int FILT_W      = 4,
  parameter int RELEARN_LVL = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       hc_stb,
  input  logic       cut_seen,
  input  logic       fast_rise,
  input  logic       steep_fall,
  output logic [1:0] mode,
  output logic       mode_valid
);
  det_state_t st;
  logic [1:0] hc_class;
  logic [1:0] decision;
  logic       learn_en, learn_done;
  logic       valid_en, relearn;
  logic       disagree;

  assign learn_en   = pwr_good && (st == ST_LEARN);
  assign valid_en   = pwr_good && (st == ST_VALID);
  assign disagree   = (hc_class != mode);
  assign mode_valid = (st == ST_VALID);

  dd_classify u_cls (
    .cut_seen  (cut_seen),
    .fast_rise (fast_rise),
    .steep_fall(steep_fall),
    .hc_class  (hc_class)
  );

  dd_learn #(.LEARN_HC(LEARN_HC)) u_learn (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (learn_en),
    .stb     (hc_stb),
    .hc_class(hc_class),
    .done    (learn_done),
    .decision(decision)
  );

  dd_filter #(
    .FILT_W     (FILT_W),
    .VAL_PERIOD (VAL_PERIOD),
    .RELEARN_LVL(RELEARN_LVL)
  ) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (valid_en),
    .stb     (hc_stb),
    .disagree(disagree),
    .relearn (relearn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_LEARN;
      mode <= MODE_NONE;
    end else if (!pwr_good) begin
      st   <= ST_LEARN;
      mode <= MODE_NONE;
    end else begin
      unique case (st)
        ST_LEARN: if (learn_done) begin
          st   <= ST_VALID;
          mode <= decision;
        end
        ST_VALID: if (relearn) begin
          st   <= ST_LEARN;
          mode <= MODE_NONE;
        end
        default: st <= ST_LEARN;
      endcase
    end
  end

  // R2: the unused code never shows on the output
  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);
  // R10: supply loss clears the mode on the next edge
  p_pg_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!mode_valid && mode == MODE_NONE));
  // R5: nothing changes without a strobe while powered
  p_no_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && !hc_stb) |=> ($stable(mode) && $stable(mode_valid)));
  // R3: validation starts only on a strobe
  p_rise_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_valid) |-> $past(hc_stb));
  // R7: validation ends only on a strobe or a supply loss
  p_fall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_valid) |-> ($past(hc_stb) || !$past(pwr_good)));
endmodule

// File: tb/dimmer_mode_det_tb.sv
module dimmer_mode_det_tb;
  localparam int LHC = 4;
  localparam int VP  = 24;
  localparam int LVL = 12;
  localparam int FW  = 4;
  localparam int FMX = 15;

  logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b0, hc_stb = 1'b0;
  logic cut_seen = 1'b0, fast_rise = 1'b0, steep_fall = 1'b0;
  logic [1:0] mode;
  logic       mode_valid;

  always #4 clk = ~clk;

  dimmer_mode_det #(.LEARN_HC(LHC), .VAL_PERIOD(VP), .FILT_W(FW), .RELEARN_LVL(LVL)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .hc_stb(hc_stb),
    .cut_seen(cut_seen), .fast_rise(fast_rise), .steep_fall(steep_fall),
    .mode(mode), .mode_valid(mode_valid)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  int m_val, m_mode, m_cnt, m_f, m_pc;
  int m_t [3];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  function automatic int hc_kind(bit c, bit r, bit f);
    if (c == 0) return 0;
    if (r == 1) return 1;
    return (f == 1) ? 2 : 1;
  endfunction

  task automatic m_restart();
    m_val = 0; m_mode = 0; m_cnt = 0; m_f = 0; m_pc = 0;
    m_t[0] = 0; m_t[1] = 0; m_t[2] = 0;
  endtask

  task automatic m_step(int k);
    if (m_val == 0) begin
      m_t[k] = m_t[k] + 1;
      m_cnt  = m_cnt + 1;
      if (m_cnt == LHC) begin
        int best = 0;
        for (int j = 1; j < 3; j++) if (m_t[j] > m_t[best]) best = j;
        m_restart();
        m_val = 1; m_mode = best;
      end
    end else begin
      if (k != m_mode) m_f = (m_f + 1 > FMX) ? FMX : m_f + 1;
      else             m_f = (m_f - 1 < 0) ? 0 : m_f - 1;
      m_pc = m_pc + 1;
      if (m_pc == VP) begin
        m_pc = 0;
        if (m_f >= LVL) m_restart();
      end
    end
  endtask

  task automatic check(string tag);
    logic [2:0] exp_v, got_v;
    exp_v = {m_val[0], m_mode[1:0]};
    got_v = {mode_valid, mode};
    n_cmp++;
    if (got_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got valid=%0d mode=%0d, expected valid=%0d mode=%0d",
               tag, got_v[2], got_v[1:0], exp_v[2], exp_v[1:0]);
    end
  endtask

  task automatic send(bit c, bit r, bit f, int gap);
    @(negedge clk);
    cut_seen = c; fast_rise = r; steep_fall = f; hc_stb = 1'b1;
    @(negedge clk);
    hc_stb = 1'b0;
    if (pwr_good) m_step(hc_kind(c, r, f));
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_k(int k);
    case (k)
      0: send(1'b0, 1'b1, 1'b1, 0);
      1: send(1'b1, 1'b1, 1'b0, 0);
      default: send(1'b1, 1'b0, 1'b1, 0);
    endcase
  endtask

  task automatic pg_cycle();
    @(negedge clk); pwr_good = 1'b0;
    @(negedge clk); pwr_good = 1'b1;
    m_restart();
  endtask

  task automatic learn_as(int k);
    pg_cycle();
    repeat (LHC) send_k(k);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got %0d cycles, expected completion", cyc);
        summary();
        $finish;
      end
    end
  end

  initial begin
    m_restart();
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset, supply low");
    // R10: strobes while supply is low are ignored
    send(1'b1, 1'b1, 1'b0, 1);
    check("R10 strobe ignored without supply");
    pwr_good = 1'b1;
    @(negedge clk);

    // R2: all eight flag combinations, held through a whole learn phase
    for (int v = 0; v < 8; v++) begin
      pg_cycle();
      repeat (LHC) send(v[2], v[1], v[0], 0);
      check($sformatf("R2 flags=%0d", v));
    end

    // R3: no decision one strobe early, decision on the last strobe
    pg_cycle();
    repeat (LHC - 1) send_k(2);
    check("R3 before last learn strobe");
    send_k(2);
    check("R3 on last learn strobe");

    // R4: every ordered sequence of four learn classes
    for (int s = 0; s < 81; s++) begin
      pg_cycle();
      send_k(s % 3); send_k((s / 3) % 3); send_k((s / 9) % 3); send_k((s / 27) % 3);
      check($sformatf("R4 seq=%0d", s));
    end

    // R5: flags toggling without a strobe, in learn and in validate
    pg_cycle();
    send_k(2); send_k(2);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); cut_seen = i[0]; fast_rise = i[1]; steep_fall = i[2];
    end
    check("R5 learn unaffected");
    send_k(2); send_k(2);
    check("R5 learn count kept");
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); cut_seen = ~i[0]; fast_rise = i[2]; steep_fall = i[1];
    end
    check("R5 validate unaffected");

    // R9: one disagreeing half-cycle leaves the mode alone
    learn_as(1);
    send_k(2);
    check("R9 single glitch");
    repeat (VP - 1) send_k(1);
    check("R9 at check point");

    // R7: a full period of disagreement re-enters learning on its last strobe
    learn_as(1);
    repeat (VP - 1) send_k(0);
    check("R7 before check point");
    send_k(0);
    check("R7 at check point");

    // R6: top saturation (18 up, 6 down ends at 9, unsaturated would be 12)
    learn_as(2);
    repeat (18) send_k(0);
    repeat (6) send_k(2);
    check("R6 upper saturation");
    // R6: bottom saturation (10 down, 14 up ends at 14, unsaturated would be 4)
    learn_as(2);
    repeat (10) send_k(2);
    repeat (14) send_k(1);
    check("R6 lower saturation");

    // R8: value carries across a check point
    learn_as(1);
    repeat (20) send_k(0);
    repeat (4) send_k(1);
    check("R8 below level stays");
    for (int i = 0; i < 11; i++) begin send_k(1); send_k(0); end
    send_k(0);
    check("R8 before second check point");
    send_k(0);
    check("R8 carried value relearns");

    // R10: supply drop in validate, then a fresh learn
    learn_as(1);
    @(negedge clk); pwr_good = 1'b0;
    @(negedge clk);
    m_restart();
    check("R10 supply drop clears");
    pwr_good = 1'b1;
    repeat (LHC) send_k(0);
    check("R10 relearn after supply");

    // R7 R8 R6: long pseudo-random run against the model
    for (int i = 0; i < 3000; i++) begin
      int k;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (m_val == 1 && lfsr[3:1] < 3'd5) k = m_mode;
      else k = int'(lfsr[15:8]) % 3;
      if (lfsr[27:20] == 8'd7) pg_cycle();
      send(k != 0, k == 1 ? 1'b1 : lfsr[9] & (k == 0), k == 2 ? 1'b1 : lfsr[11], int'(lfsr[17:16]) % 3);
      check("R7 random run");
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule